// File: doc/BRIEF.md
# Stop Mode Release Sequencer

This block decides when a small microcontroller goes into its lowest-power STOP state and how it comes back out. Software pulses a request and the block shuts off every oscillator enable. It also halts the CPU and the peripherals. At that same edge it captures the clock configuration, the warm-up choice and the flash power-down choice.

STOP ends in one of two ways. A rising edge on the wake pin starts an orderly release. The block clears the timing-generator divider and turns the right oscillators back on. It then counts one of four warm-up lengths while everything stays halted. When flash power-down was selected, it adds a CPU-wait phase in which the peripherals run again but the CPU stays stalled. A low level on the external reset pin during STOP skips all of this and raises a reset request instead.

Top module: `stop_release_seq`

## Requirements
- R1: After reset the block is running: `cpu_halt`, `periph_halt`, `div_clr`, `reset_req` and `resume` are 0, `osc_hi_en` is 1 and `osc_lo_en` is 0.
- R2: A `stop_req` sampled high while running enters STOP at that edge. From then on `cpu_halt` and `periph_halt` are 1 and both oscillator enables are 0. A `stop_req` sampled in any other state has no effect.
- R3: Only a 0-to-1 change of `wake` observed while in STOP starts the release. A wake level that is already high when STOP is entered does not start it. Wake activity while running or warming up is ignored.
- R4: The warm-up length is picked by `wu_sel`, latched at STOP entry: 0 gives WU0, 1 gives WU1, 2 gives WU2 and 3 gives WU3 cycles. `periph_halt` stays 1 for exactly that many cycles after the edge that saw the wake rise.
- R5: With `flash_pd` latched as 0, `cpu_halt` and `periph_halt` drop in the same cycle when warm-up ends.
- R6: With `flash_pd` latched as 1, a CPU-wait of CWAIT cycles follows warm-up. During it `periph_halt` is 0 and `cpu_halt` is 1.
- R7: `div_clr` is high for exactly one cycle, the first cycle after the wake edge is taken.
- R8: From the wake edge onward, the oscillator enables follow the mode latched at STOP entry. With `dual_clk`=1 and `ret_slow`=0 both are on. With `dual_clk`=1 and `ret_slow`=1 only `osc_lo_en` is on. With `dual_clk`=0, only `osc_hi_en` is on, whatever `ret_slow` is.
- R9: A low `rst_pin_n` sampled in STOP leaves STOP at once. It gives a one-cycle `reset_req`, releases the halts and runs no warm-up. It takes priority over a simultaneous wake edge.
- R10: `resume` pulses for exactly one cycle, the first cycle in which `cpu_halt` is 0 after a wake release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req | input | 1 | One-cycle request to enter STOP |
| wake | input | 1 | Wake pin; a rising edge releases STOP |
| rst_pin_n | input | 1 | External reset pin level, active low |
| wu_sel | input | 2 | Warm-up length select |
| flash_pd | input | 1 | Adds the CPU-wait phase when 1 |
| dual_clk | input | 1 | 1 = dual-clock configuration |
| ret_slow | input | 1 | 1 = return to the slow mode |
| osc_hi_en | output | 1 | High-frequency oscillator enable |
| osc_lo_en | output | 1 | Low-frequency oscillator enable |
| cpu_halt | output | 1 | Stalls the CPU |
| periph_halt | output | 1 | Stalls peripherals and the timing generator |
| div_clr | output | 1 | Clears the prescaler and timing-generator divider |
| reset_req | output | 1 | Request to the normal reset path |
| resume | output | 1 | One-cycle pulse when the CPU is released |

## Verification
Every output comes straight from one register stage. A wake rise driven before edge e shows its effects in the cycle after e: oscillator enables on and `div_clr` high. `periph_halt` then stays high for exactly the selected warm-up count. With flash power-down on, `cpu_halt` stays high for CWAIT further cycles, and `resume` appears in the first cycle with `cpu_halt` low. The bench drives inputs on falling edges and counts falling-edge samples from that first cycle. It compares those counts with the warm-up value it computes for the configuration, plus CWAIT when flash power-down is on. It sweeps every select, flash and clock-mode combination. The reset-pin exit is expected one cycle after the sampling edge.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STOP  = 2'd1,
        ST_WARM  = 2'd2,
        ST_CWAIT = 2'd3
    } srs_state_e;

    typedef struct packed {
        logic       dual;
        logic       slow;
        logic [1:0] wsel;
        logic       pdn;
    } srs_cfg_t;

endpackage

// File: rtl/srs_edge.sv
module srs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;   // a high level at reset is not an edge
        else        prev_q <= prev_d;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/srs_osc_map.sv
module srs_osc_map (
    input  logic active,
    input  logic dual,
    input  logic slow,
    output logic hi_en,
    output logic lo_en
);
    always_comb begin
        hi_en = active & (~dual | ~slow);
        lo_en = active & dual;
    end
endmodule

// File: rtl/srs_wu_len.sv
module srs_wu_len #(
    parameter int WU0 = 16384,
    parameter int WU1 = 4096,
    parameter int WU2 = 1024,
    parameter int WU3 = 256,
    parameter int W   = 15
) (
    input  logic [1:0]   sel,
    output logic [W-1:0] load
);
    localparam int NOPT = 4;
    localparam int LENS [NOPT] = '{WU0, WU1, WU2, WU3};

    logic [W-1:0] opt [NOPT];

    for (genvar g = 0; g < NOPT; g++) begin : g_opt
        assign opt[g] = W'(LENS[g] - 1);
    end

    assign load = opt[sel];
endmodule

// File: rtl/stop_release_seq.sv
module stop_release_seq
    import srs_pkg::*;
#(
    parameter int WU0   = 16384,
    parameter int WU1   = 4096,
    parameter int WU2   = 1024,
    parameter int WU3   = 256,
    parameter int CWAIT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake,
    input  logic       rst_pin_n,
    input  logic [1:0] wu_sel,
    input  logic       flash_pd,
    input  logic       dual_clk,
    input  logic       ret_slow,
    output logic       osc_hi_en,
    output logic       osc_lo_en,
    output logic       cpu_halt,
    output logic       periph_halt,
    output logic       div_clr,
    output logic       reset_req,
    output logic       resume
);
    localparam int M01   = (WU0 > WU1) ? WU0 : WU1;
    localparam int M23   = (WU2 > WU3) ? WU2 : WU3;
    localparam int MWU   = (M01 > M23) ? M01 : M23;
    localparam int MAXC  = (MWU > CWAIT) ? MWU : CWAIT;
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        srs_state_e         st;
        srs_cfg_t           cfg;
        logic [CNT_W-1:0]   cnt;
        logic               clr;
        logic               rreq;
        logic               done;
    } regs_t;

    regs_t r_d, r_q;

    logic             wake_rise;
    logic [CNT_W-1:0] wu_load;
    srs_state_e       st_q;

    srs_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wake),
        .rise (wake_rise)
    );

    srs_wu_len #(
        .WU0(WU0), .WU1(WU1), .WU2(WU2), .WU3(WU3), .W(CNT_W)
    ) u_len (
        .sel (r_q.cfg.wsel),
        .load(wu_load)
    );

    srs_osc_map u_osc (
        .active(r_q.st != ST_STOP),
        .dual  (r_q.cfg.dual),
        .slow  (r_q.cfg.slow),
        .hi_en (osc_hi_en),
        .lo_en (osc_lo_en)
    );

    always_comb begin
        r_d      = r_q;
        r_d.clr  = 1'b0;
        r_d.rreq = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                r_d.cfg = '{dual: dual_clk, slow: ret_slow, wsel: wu_sel, pdn: flash_pd};
                if (stop_req) r_d.st = ST_STOP;
            end
            ST_STOP: begin
                if (!rst_pin_n) begin
                    r_d.st   = ST_RUN;
                    r_d.rreq = 1'b1;
                end else if (wake_rise) begin
                    r_d.st  = ST_WARM;
                    r_d.cnt = wu_load;
                    r_d.clr = 1'b1;
                end
            end
            ST_WARM: begin
                if (r_q.cnt == '0) begin
                    if (r_q.cfg.pdn) begin
                        r_d.st  = ST_CWAIT;
                        r_d.cnt = CNT_W'(CWAIT - 1);
                    end else begin
                        r_d.st   = ST_RUN;
                        r_d.done = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_CWAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_RUN;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RUN;
            r_q.cfg  <= '0;
            r_q.cnt  <= '0;
            r_q.clr  <= 1'b0;
            r_q.rreq <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q        = r_q.st;
    assign cpu_halt    = (r_q.st != ST_RUN);
    assign periph_halt = (r_q.st == ST_STOP) || (r_q.st == ST_WARM);
    assign div_clr     = r_q.clr;
    assign reset_req   = r_q.rreq;
    assign resume      = r_q.done;
endmodule

// File: rtl/srs_chk.sv
module srs_chk
    import srs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input srs_state_e st,
    input logic       stop_req,
    input logic       rst_pin_n,
    input logic       osc_hi_en,
    input logic       osc_lo_en,
    input logic       cpu_halt,
    input logic       periph_halt,
    input logic       div_clr,
    input logic       reset_req,
    input logic       resume
);
    // R2: in STOP every oscillator is off and both halts are on
    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |-> (!osc_hi_en && !osc_lo_en && cpu_halt && periph_halt));

    // R2: a request outside RUN does not lead to STOP
    a_r2_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WARM && stop_req) |=> (st != ST_STOP));

    // R4: everything halted during warm-up
    a_r4_warm_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WARM) |-> (cpu_halt && periph_halt));

    // R6: CPU-wait lets peripherals run while the CPU waits
    a_r6_cwait_split: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CWAIT) |-> (cpu_halt && !periph_halt));

    // R7: divider clear only on the first warm-up cycle
    a_r7_clr_entry: assert property (@(posedge clk) disable iff (!rst_n)
        div_clr |-> (st == ST_WARM && $past(st) == ST_STOP));

    // R9: reset request only after a low reset pin seen in STOP
    a_r9_rreq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($past(st) == ST_STOP && !$past(rst_pin_n) && !cpu_halt));

    // R10: resume is a single-cycle pulse with the CPU free
    a_r10_resume_once: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    a_r10_resume_free: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (!cpu_halt && $past(cpu_halt)));
endmodule

bind stop_release_seq srs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .stop_req   (stop_req),
    .rst_pin_n  (rst_pin_n),
    .osc_hi_en  (osc_hi_en),
    .osc_lo_en  (osc_lo_en),
    .cpu_halt   (cpu_halt),
    .periph_halt(periph_halt),
    .div_clr    (div_clr),
    .reset_req  (reset_req),
    .resume     (resume)
);

// File: tb/sim_stop_release_seq.sv
module sim_stop_release_seq;
    localparam int WU0 = 12, WU1 = 7, WU2 = 4, WU3 = 2, CW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, wake = 0, rst_pin_n = 1, flash_pd = 0, dual_clk = 0, ret_slow = 0;
    logic [1:0] wu_sel = 0;
    logic osc_hi_en, osc_lo_en, cpu_halt, periph_halt, div_clr, reset_req, resume;

    int total = 0, fails = 0;

    always #5 clk = ~clk;

    stop_release_seq #(.WU0(WU0), .WU1(WU1), .WU2(WU2), .WU3(WU3), .CWAIT(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake(wake), .rst_pin_n(rst_pin_n),
        .wu_sel(wu_sel), .flash_pd(flash_pd), .dual_clk(dual_clk), .ret_slow(ret_slow),
        .osc_hi_en(osc_hi_en), .osc_lo_en(osc_lo_en), .cpu_halt(cpu_halt),
        .periph_halt(periph_halt), .div_clr(div_clr), .reset_req(reset_req), .resume(resume)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wu_len(input int s);
        case (s)
            0: return WU0;
            1: return WU1;
            2: return WU2;
            default: return WU3;
        endcase
    endfunction

    task automatic enter_stop();
        @(negedge clk) stop_req = 1;
        @(negedge clk) stop_req = 0;
    endtask

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cpu_halt", cpu_halt, 0);
        chk("R1 periph_halt", periph_halt, 0);
        chk("R1 osc", {osc_hi_en, osc_lo_en}, 2'b10);
        chk("R1 pulses", {div_clr, reset_req, resume}, 0);
        rst_n = 1;
        @(negedge clk);

        // R3 wake toggles while running are ignored
        for (int i = 0; i < 3; i++) begin
            wake = 1; @(negedge clk);
            chk("R3 run wake ignored", {cpu_halt, periph_halt, resume, div_clr}, 0);
            wake = 0; @(negedge clk);
        end

        // sweep of all configurations
        for (int s = 0; s < 4; s++)
        for (int p = 0; p < 2; p++)
        for (int d = 0; d < 2; d++)
        for (int sl = 0; sl < 2; sl++) begin
            int n, m, exp_hi, exp_lo;
            wu_sel = 2'(s); flash_pd = p[0]; dual_clk = d[0]; ret_slow = sl[0];
            enter_stop();
            chk("R2 stop entry", {cpu_halt, periph_halt, osc_hi_en, osc_lo_en}, 4'b1100);
            // scramble live inputs: latched values must rule (R8, R4)
            wu_sel = ~wu_sel; flash_pd = ~flash_pd; dual_clk = ~dual_clk; ret_slow = ~ret_slow;
            repeat (3) @(negedge clk);
            chk("R3 stays stopped", {cpu_halt, periph_halt}, 2'b11);
            wake = 1;
            @(negedge clk);
            exp_hi = (d == 0 || sl == 0) ? 1 : 0;
            exp_lo = d;
            chk("R8 osc on release", {osc_hi_en, osc_lo_en}, {exp_hi[0], exp_lo[0]});
            chk("R7 div_clr first", div_clr, 1);
            stop_req = 1;   // R2: ignored during warm-up
            n = 0;
            while (periph_halt && n < 100) begin
                n++;
                @(negedge clk);
                stop_req = 0;
                if (n == 1) chk("R7 div_clr single", div_clr, 0);
            end
            chk("R4 warm-up length", n, wu_len(s));
            if (p == 0) begin
                chk("R5 cpu with periph", cpu_halt, 0);
            end else begin
                m = 0;
                while (cpu_halt && m < 100) begin
                    m++;
                    chk("R6 periph runs", periph_halt, 0);
                    @(negedge clk);
                end
                chk("R6 cpu-wait length", m, CW);
            end
            chk("R10 resume", resume, 1);
            wake = 0;
            @(negedge clk);
            chk("R10 resume single", resume, 0);
            chk("R2 no re-entry", cpu_halt, 0);
        end

        // R3 wake high at entry is not an edge
        wu_sel = 3; flash_pd = 0; dual_clk = 0;
        wake = 1;
        @(negedge clk);
        enter_stop();
        repeat (4) @(negedge clk);
        chk("R3 level not edge", {cpu_halt, div_clr}, 2'b10);
        wake = 0; @(negedge clk);
        wake = 1; @(negedge clk);
        chk("R3 later edge", div_clr, 1);
        repeat (WU3 + 2) @(negedge clk);
        wake = 0;
        chk("R3 released", cpu_halt, 0);

        // R9 reset pin wins over simultaneous wake
        enter_stop();
        @(negedge clk);
        rst_pin_n = 0; wake = 1;
        @(negedge clk);
        chk("R9 reset_req", reset_req, 1);
        chk("R9 no warm-up", {cpu_halt, periph_halt, div_clr}, 0);
        @(negedge clk);
        chk("R9 reset_req single", reset_req, 0);
        chk("R9 no resume", resume, 0);
        rst_pin_n = 1; wake = 0;
        @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule